// File: doc/BRIEF.md
# Blitter control register file

This block is the host-facing register file of a planar graphics blitter. The host reaches it through eight even word offsets in a 16-byte window. It writes the fields that steer the blitter: which planes may be written, where the colour comes from, the lead plane, the source and load modes, the raster-op code, the two colour registers, the bit mask and the shifter set-up. Every field drives an output port of its own, so the shifter and memory datapath can use the fields directly.

The whole window exists only while the blitter-mode enable is high. When that enable is low, writes do nothing and reads return all ones. The foreground and background colours are also presented as per-plane masks, each a 16-bit word of all ones or all zeros. Any write to the shifter parameters raises a one-cycle reinitialise strobe. Accesses that are narrower than a word, or that use an odd offset, raise a one-cycle illegal-access pulse and change nothing. The one exception is a byte write to the foreground colour offset, which is accepted.

Top module: `blit_regs`

## Requirements
- R1: While `mode_en` is low, no write changes any output field, and neither `shift_reinit` nor `illegal` pulses.
- R2: `rdata` reads all ones, whether `mode_en` is high or low.
- R3: A word write to offset 0 sets `plane_we` to bits 7:0 of the written data.
- R4: A word write to offset 2 sets `color_sel` from bits 14:13 (00 pattern, 01 background, 10 foreground) and `lead_plane` from bits 11:8.
- R5: A word write to offset 4 sets `cmp_lead` to the inverse of bit 13, `wr_src` from bits 12:11, `shift_in` from bit 10, `load_mode` from bits 9:8 and `rop` from bits 7:0.
- R6: A write to offset 6 sets `fg_color` to data bits 7:0, and a write to offset 10 sets `bg_color` the same way. For each plane p from 0 to 3, the matching mask word (`fg_mask` or `bg_mask`, bits 16p+15 to 16p) becomes 0xFFFF when colour bit p is 1 and 0x0000 when it is 0.
- R7: A word write to offset 8 loads `bit_mask` with all 16 data bits only while `cmp_lead` is 0. Otherwise the mask keeps its value.
- R8: A word write to offset 12 sets `shift_desc` from bit 12, `dst_bit` from bits 7:4 and `src_bit` from bits 3:0. A word write to offset 14 sets `bit_len` from bits 11:0.
- R9: `shift_reinit` is high for exactly the one cycle after each accepted write to offset 12 or 14, and for no other write.
- R10: A byte write (`byte_acc` high) to offset 6 behaves exactly like the word write to offset 6.
- R11: Every other byte access, and every access at an odd offset, changes no field and pulses `illegal` high for the one cycle after the access.
- R12: After reset `rop` is 0xF0, `bit_len` is 0x00F, and every other field, mask and strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Blitter-mode enable; the window exists only while high |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| byte_acc | input | 1 | 1 = byte-sized access, 0 = word access |
| addr | input | 4 | Byte offset inside the window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (all ones) |
| plane_we | output | 8 | Plane write enables |
| color_sel | output | 2 | Colour source select |
| lead_plane | output | 4 | Lead plane number |
| cmp_lead | output | 1 | Compare-lead flag, stored inverted |
| wr_src | output | 2 | Write source select |
| shift_in | output | 1 | Shifter input select |
| load_mode | output | 2 | Pattern register load mode |
| rop | output | 8 | Raster-op code |
| fg_color | output | 8 | Foreground colour |
| bg_color | output | 8 | Background colour |
| fg_mask | output | 64 | Foreground per-plane masks, 16 bits per plane |
| bg_mask | output | 64 | Background per-plane masks, 16 bits per plane |
| bit_mask | output | 16 | Bit mask |
| shift_desc | output | 1 | Shift direction, 1 = descend |
| dst_bit | output | 4 | Destination bit address |
| src_bit | output | 4 | Source bit address |
| bit_len | output | 12 | Bit length |
| shift_reinit | output | 1 | One-cycle shifter reinitialise strobe |
| illegal | output | 1 | One-cycle illegal-access pulse |

## Verification
The bench loads the bit mask under both compare-lead states. A design that gated on the written bit rather than the stored, inverted flag would either lose the mask or overwrite it. It writes colours whose bits alternate, so a mask driven from the wrong colour bit shows up as a wrong plane word. It issues a byte write to the foreground offset next to byte and odd-offset writes elsewhere, catching a decoder that either rejects the legal byte form or lets an illegal access update a field. It also writes with the mode enable low and checks the strobe after writes to shifter and non-shifter offsets, which exposes a window that never disappears or a strobe that fires on the wrong offsets.

// File: rtl/blit_regs.sv
module blit_regs #(
  parameter int PLANES = 4,
  parameter int MASK_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_en,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     byte_acc,
  input  logic [3:0]               addr,
  input  logic [15:0]              wdata,
  output logic [15:0]              rdata,
  output logic [7:0]               plane_we,
  output logic [1:0]               color_sel,
  output logic [3:0]               lead_plane,
  output logic                     cmp_lead,
  output logic [1:0]               wr_src,
  output logic                     shift_in,
  output logic [1:0]               load_mode,
  output logic [7:0]               rop,
  output logic [7:0]               fg_color,
  output logic [7:0]               bg_color,
  output logic [PLANES*MASK_W-1:0] fg_mask,
  output logic [PLANES*MASK_W-1:0] bg_mask,
  output logic [MASK_W-1:0]        bit_mask,
  output logic                     shift_desc,
  output logic [3:0]               dst_bit,
  output logic [3:0]               src_bit,
  output logic [11:0]              bit_len,
  output logic                     shift_reinit,
  output logic                     illegal
);

  logic acc, word_ok, fg_byte, wr;

  assign acc     = mode_en & (wr_en | rd_en);
  assign word_ok = ~byte_acc & ~addr[0];
  assign fg_byte = wr_en & byte_acc & (addr == 4'd6);
  assign wr      = mode_en & wr_en & word_ok;
  assign rdata   = '1;

  function automatic logic [PLANES*MASK_W-1:0] expand(input logic [7:0] c);
    logic [PLANES*MASK_W-1:0] m;
    for (int p = 0; p < PLANES; p++) m[p*MASK_W +: MASK_W] = {MASK_W{c[p]}};
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plane_we     <= '0;
      color_sel    <= '0;
      lead_plane   <= '0;
      cmp_lead     <= 1'b0;
      wr_src       <= '0;
      shift_in     <= 1'b0;
      load_mode    <= '0;
      rop          <= 8'hF0;
      fg_color     <= '0;
      bg_color     <= '0;
      fg_mask      <= '0;
      bg_mask      <= '0;
      bit_mask     <= '0;
      shift_desc   <= 1'b0;
      dst_bit      <= '0;
      src_bit      <= '0;
      bit_len      <= 12'h00F;
      shift_reinit <= 1'b0;
      illegal      <= 1'b0;
    end else begin
      shift_reinit <= wr & ((addr == 4'd12) | (addr == 4'd14));
      illegal      <= acc & ~word_ok & ~fg_byte;
      if (mode_en & fg_byte) begin
        fg_color <= wdata[7:0];
        fg_mask  <= expand(wdata[7:0]);
      end
      if (wr) begin
        unique case (addr[3:1])
          3'd0: plane_we <= wdata[7:0];
          3'd1: begin
            color_sel  <= wdata[14:13];
            lead_plane <= wdata[11:8];
          end
          3'd2: begin
            cmp_lead  <= ~wdata[13];
            wr_src    <= wdata[12:11];
            shift_in  <= wdata[10];
            load_mode <= wdata[9:8];
            rop       <= wdata[7:0];
          end
          3'd3: begin
            fg_color <= wdata[7:0];
            fg_mask  <= expand(wdata[7:0]);
          end
          3'd4: if (!cmp_lead) bit_mask <= wdata[MASK_W-1:0];
          3'd5: begin
            bg_color <= wdata[7:0];
            bg_mask  <= expand(wdata[7:0]);
          end
          3'd6: begin
            shift_desc <= wdata[12];
            dst_bit    <= wdata[7:4];
            src_bit    <= wdata[3:0];
          end
          3'd7: bit_len <= wdata[11:0];
          default: ;
        endcase
      end
    end
  end

endmodule

module blit_regs_chk #(
  parameter int PLANES = 4,
  parameter int MASK_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mode_en,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic                     byte_acc,
  input logic [3:0]               addr,
  input logic [7:0]               plane_we,
  input logic [7:0]               rop,
  input logic                     cmp_lead,
  input logic [7:0]               fg_color,
  input logic [7:0]               bg_color,
  input logic [PLANES*MASK_W-1:0] fg_mask,
  input logic [PLANES*MASK_W-1:0] bg_mask,
  input logic [MASK_W-1:0]        bit_mask,
  input logic [11:0]              bit_len,
  input logic                     shift_reinit,
  input logic                     illegal
);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> ($stable(plane_we) && $stable(rop) && $stable(bit_len) && !shift_reinit && !illegal));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_lead |=> $stable(bit_mask));

  p_reinit_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_reinit) |-> $past(mode_en && wr_en && !byte_acc && (addr == 4'd12 || addr == 4'd14)));

  p_illegal_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(mode_en && (wr_en || rd_en) && (byte_acc || addr[0])));

  for (genvar p = 0; p < PLANES; p++) begin : g_planes
    p_fgmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fg_mask[p*MASK_W +: MASK_W] == {MASK_W{fg_color[p]}});
    p_bgmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bg_mask[p*MASK_W +: MASK_W] == {MASK_W{bg_color[p]}});
  end

endmodule

bind blit_regs blit_regs_chk #(.PLANES(PLANES), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .wr_en(wr_en), .rd_en(rd_en),
  .byte_acc(byte_acc), .addr(addr), .plane_we(plane_we), .rop(rop),
  .cmp_lead(cmp_lead), .fg_color(fg_color), .bg_color(bg_color),
  .fg_mask(fg_mask), .bg_mask(bg_mask), .bit_mask(bit_mask),
  .bit_len(bit_len), .shift_reinit(shift_reinit), .illegal(illegal)
);

// File: tb/blit_regs_test.sv
module blit_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, byte_acc = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  plane_we, rop, fg_color, bg_color;
  logic [1:0]  color_sel, wr_src, load_mode;
  logic [3:0]  lead_plane, dst_bit, src_bit;
  logic        cmp_lead, shift_in, shift_desc, shift_reinit, illegal;
  logic [63:0] fg_mask, bg_mask;
  logic [15:0] bit_mask;
  logic [11:0] bit_len;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  blit_regs uut (.*);

  // entry: {req, addr, wdata, field select, expected}
  localparam int NV = 27;
  localparam logic [43:0] VEC [NV] = '{
    {4'd3,  4'd0,  16'hFFA5, 4'd0,  16'h00A5},  // R3
    {4'd4,  4'd2,  16'h4B00, 4'd1,  16'h0002},  // R4 foreground select
    {4'd4,  4'd2,  16'h4B00, 4'd2,  16'h000B},  // R4 lead plane
    {4'd4,  4'd2,  16'h2300, 4'd1,  16'h0001},  // R4 background select
    {4'd5,  4'd4,  16'h1E3C, 4'd3,  16'h0001},  // R5 bit13=0 -> cmp_lead=1
    {4'd5,  4'd4,  16'h1E3C, 4'd4,  16'h0003},  // R5
    {4'd5,  4'd4,  16'h1E3C, 4'd5,  16'h0001},  // R5
    {4'd5,  4'd4,  16'h1E3C, 4'd6,  16'h0002},  // R5
    {4'd5,  4'd4,  16'h1E3C, 4'd7,  16'h003C},  // R5
    {4'd7,  4'd8,  16'h1234, 4'd11, 16'h0000},  // R7 blocked
    {4'd5,  4'd4,  16'h20F0, 4'd3,  16'h0000},  // R5 bit13=1 -> cmp_lead=0
    {4'd7,  4'd8,  16'h1234, 4'd11, 16'h1234},  // R7 loaded
    {4'd6,  4'd6,  16'h0006, 4'd8,  16'h0006},  // R6
    {4'd6,  4'd6,  16'h0006, 4'd9,  16'hFFFF},  // R6 plane 1 set
    {4'd6,  4'd6,  16'h00F9, 4'd9,  16'h0000},  // R6 plane 1 clear
    {4'd6,  4'd10, 16'h0008, 4'd10, 16'hFFFF},  // R6 plane 3 set
    {4'd6,  4'd10, 16'h0007, 4'd10, 16'h0000},  // R6 plane 3 clear
    {4'd6,  4'd10, 16'h00C5, 4'd12, 16'h00C5},  // R6 bg colour
    {4'd8,  4'd12, 16'h10A5, 4'd13, 16'h0001},  // R8
    {4'd8,  4'd12, 16'h10A5, 4'd14, 16'h000A},  // R8
    {4'd8,  4'd12, 16'h10A5, 4'd15, 16'h0005},  // R8
    {4'd8,  4'd12, 16'h0036, 4'd13, 16'h0000},  // R8 ascend
    {4'd8,  4'd14, 16'hFABC, 4'd0,  16'h0ABC},  // R8 length (sel 0 reused below)
    {4'd8,  4'd14, 16'h0FFF, 4'd0,  16'h0FFF},  // R8
    {4'd3,  4'd0,  16'h005A, 4'd0,  16'h005A},  // R3
    {4'd7,  4'd8,  16'hBEEF, 4'd11, 16'hBEEF},  // R7
    {4'd5,  4'd4,  16'h2000, 4'd7,  16'h0000}   // R5
  };

  function automatic logic [15:0] field(input logic [3:0] sel, input logic [3:0] a);
    case (sel)
      4'd0:  return (a == 4'd14) ? {4'd0, bit_len} : {8'd0, plane_we};
      4'd1:  return {14'd0, color_sel};
      4'd2:  return {12'd0, lead_plane};
      4'd3:  return {15'd0, cmp_lead};
      4'd4:  return {14'd0, wr_src};
      4'd5:  return {15'd0, shift_in};
      4'd6:  return {14'd0, load_mode};
      4'd7:  return {8'd0, rop};
      4'd8:  return {8'd0, fg_color};
      4'd9:  return fg_mask[31:16];
      4'd10: return bg_mask[63:48];
      4'd11: return bit_mask;
      4'd12: return {8'd0, bg_color};
      4'd13: return {15'd0, shift_desc};
      4'd14: return {12'd0, dst_bit};
      default: return {12'd0, src_bit};
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic b, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = w; rd_en = ~w; byte_acc = b; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; byte_acc = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 rop", rop, 8'hF0);
    check("R12 bit_len", bit_len, 12'h00F);
    check("R12 others", {plane_we, color_sel, lead_plane, cmp_lead, wr_src, shift_in,
                         load_mode, fg_color, bg_color, bit_mask, shift_desc, dst_bit, src_bit},
          '0);
    check("R12 masks", {fg_mask, bg_mask}, '0);
    check("R12 strobes", {shift_reinit, illegal}, 2'b00);

    // R1 writes ignored while disabled, R2 reads all ones
    access(1'b1, 1'b0, 4'd0, 16'h00FF);
    check("R1 plane_we", plane_we, 8'h00);
    access(1'b1, 1'b0, 4'd14, 16'h0123);
    check("R1 bit_len", bit_len, 12'h00F);
    check("R1 no strobe", shift_reinit, 1'b0);
    access(1'b1, 1'b1, 4'd3, 16'h0000);
    check("R1 no illegal", illegal, 1'b0);
    check("R2 disabled", rdata, 16'hFFFF);

    mode_en = 1'b1;
    access(1'b0, 1'b0, 4'd4, 16'h0000);
    check("R2 enabled", rdata, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      access(1'b1, 1'b0, VEC[i][39:36], VEC[i][35:20]);
      check($sformatf("R%0d vector %0d", VEC[i][43:40], i),
            field(VEC[i][19:16], VEC[i][39:36]), VEC[i][15:0]);
    end

    // R9 strobe timing
    access(1'b1, 1'b0, 4'd14, 16'h0010);
    check("R9 strobe after len write", shift_reinit, 1'b1);
    @(negedge clk);
    check("R9 strobe one cycle", shift_reinit, 1'b0);
    access(1'b1, 1'b0, 4'd12, 16'h0000);
    check("R9 strobe after shift write", shift_reinit, 1'b1);
    access(1'b1, 1'b0, 4'd0, 16'h0001);
    check("R9 no strobe other offset", shift_reinit, 1'b0);

    // R10 byte write to foreground
    access(1'b1, 1'b1, 4'd6, 16'h000A);
    check("R10 fg_color", fg_color, 8'h0A);
    check("R10 fg_mask", fg_mask, 64'hFFFF_0000_FFFF_0000);
    check("R10 no illegal", illegal, 1'b0);

    // R11 illegal accesses
    access(1'b1, 1'b1, 4'd0, 16'h00EE);
    check("R11 byte pulse", illegal, 1'b1);
    check("R11 byte no effect", plane_we, 8'h01);
    @(negedge clk);
    check("R11 pulse one cycle", illegal, 1'b0);
    access(1'b1, 1'b0, 4'd5, 16'h0033);
    check("R11 odd pulse", illegal, 1'b1);
    check("R11 odd no effect", {plane_we, rop}, {8'h01, 8'h00});
    access(1'b1, 1'b0, 4'd13, 16'h0777);
    check("R11 odd near shift no strobe", {shift_reinit, bit_len}, {1'b0, 12'h010});
    access(1'b0, 1'b1, 4'd6, 16'h0000);
    check("R11 byte read pulse", illegal, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule